// File: doc/BRIEF.md
# Elapsed-Seconds Counter with Prescaler and Square-Wave Tap

The block keeps a 32-bit binary count of elapsed seconds. A reference clock enable, nominally pulsing at 32768 Hz, drives a two-part divider chain. The fast early stage runs freely from reset and never restarts. It provides the watchdog-rate tick and the high square-wave frequencies. The late stage turns early-stage carries into the once-per-second tick that advances the count.

Software reaches the count as four byte registers over a plain synchronous read/write port. Byte 0 holds the least significant byte. A read of byte 0 captures the whole count into a holding copy, so bytes 1 to 3 read afterwards stay consistent while counting goes on. Writes to bytes 0 to 3 fill a staging word. The write to byte 3 commits the staging word and restarts only the late divider stage. A 1 Hz square wave taken from that stage is realigned by the commit. Faster waves and the watchdog tick keep their phase.

A three-state commit machine sequences the writes:
- `S_RUN`: no write is pending. A write to bytes 0 to 2 leads to `S_STAGED`, and a write to byte 3 leads to `S_LOAD`.
- `S_STAGED`: partial bytes are staged. A write to byte 3 leads to `S_LOAD`, and further writes to lower bytes stay in `S_STAGED`.
- `S_LOAD`: this state lasts one cycle. It loads the count, clears the late stage and returns to `S_RUN`. If a new write arrives in this cycle, it goes to `S_STAGED` or `S_LOAD` by the same byte rule.

Top module: `secs_counter`

## Requirements
- R1: The count increases by exactly one on each seconds tick and wraps from FFFFFFFFh to 0. Address 0 maps to bits 7:0 and address 3 maps to bits 31:24.
- R2: `rdata` updates on the clock edge where `rd_en` is high. A read of address 0 returns the live low byte and copies the full count into a holding word. Reads of addresses 1 to 3 return bytes of that holding word, even if the count has advanced since the copy.
- R3: Writes to addresses 0 to 2 only stage a byte and leave the count unchanged. A write to address 3 moves the state machine to `S_LOAD`, and the count takes all four staged bytes on the next edge.
- R4: The load clears the late divider stage. With early-stage value e at the load edge, the next increment comes on the (2^(EARLY_W+LATE_W) − e)-th reference pulse after the load.
- R5: Square-wave select 0 (1 Hz) outputs the most significant bit of the late stage. After a load this output is low.
- R6: A load leaves the early stage untouched. `wd_tick` is high exactly while `ref_en` is high and the early stage is all ones.
- R7: `sqw_sel` selects the output as follows: 0 gives 1 Hz, 1 gives ref/2^EARLY_W (4096 Hz), 2 gives ref/2^(EARLY_W−1) (8192 Hz), and 3 gives the `ref_en` input itself (32768 Hz). With `sqw_en` low, `sqw` is low.
- R8: If a seconds tick falls in the `S_LOAD` cycle, the loaded value wins and the tick is dropped.
- R9: After reset, the count, the divider stages and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | Reference enable, one pulse per 1/32768 s |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Byte address, 0 = least significant |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid after the read edge |
| sqw_en | input | 1 | Square-wave output enable |
| sqw_sel | input | 2 | Square-wave frequency select |
| sqw | output | 1 | Square-wave output |
| wd_tick | output | 1 | Watchdog-rate tick from the early stage |

## Verification
The bench builds the block with EARLY_W=3 and LATE_W=3, so one second lasts 64 reference pulses and the 1 Hz wave has a 64-pulse period. At this size, several conditions can be reached in a few hundred cycles: a full second after a load, the all-ones chain state that collides with a load, the count carrying across a byte boundary, and the wrap of the count. The bench tracks the early-stage phase as the total pulse count modulo 8, so each next-tick distance can be computed exactly.

// File: rtl/sc_pkg.sv
package sc_pkg;
    typedef enum logic [1:0] {
        S_RUN    = 2'd0,
        S_STAGED = 2'd1,
        S_LOAD   = 2'd2
    } commit_state_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/sc_divider.sv
module sc_divider #(
    parameter int EARLY_W = 3,
    parameter int LATE_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_en,
    input  logic               late_clr,
    output logic [1:0]         early_top,
    output logic               late_msb,
    output logic               wd_tick,
    output logic               sec_tick
);
    logic [EARLY_W-1:0] early_q;
    logic [LATE_W-1:0]  late_q;

    // Early stage: free running, never restarted by a load
    always_ff @(posedge clk) begin
        if (!rst_n)
            early_q <= '0;
        else if (ref_en)
            early_q <= early_q + 1'b1;
    end

    // Late stage: restarted by a counter load
    always_ff @(posedge clk) begin
        if (!rst_n)
            late_q <= '0;
        else if (late_clr)
            late_q <= '0;
        else if (ref_en && (&early_q))
            late_q <= late_q + 1'b1;
    end

    assign wd_tick   = ref_en & (&early_q);
    assign sec_tick  = wd_tick & (&late_q);
    assign early_top = early_q[EARLY_W-1 -: 2];
    assign late_msb  = late_q[LATE_W-1];

    // R4: a load leaves the late stage at zero
    p_late_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        late_clr |=> (late_q == '0));

    // R6: early stage advances on every reference pulse, load or not
    p_early_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_en |=> (early_q == EARLY_W'($past(early_q) + 1'b1)));
endmodule

// File: rtl/sc_regs.sv
module sc_regs
    import sc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int BYTES  = CNT_W / 8,
    parameter int ADDR_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              late_clr
);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BYTES - 1);

    commit_state_t state, nxt;
    logic [CNT_W-1:0] count, staged, snap;
    logic [7:0]       snap_byte;
    logic             last_wr;

    assign last_wr = wr_en && (addr == LAST_A);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_RUN;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_RUN:    if (wr_en) nxt = last_wr ? S_LOAD : S_STAGED;
            S_STAGED: if (last_wr) nxt = S_LOAD;
            S_LOAD:   nxt = wr_en ? (last_wr ? S_LOAD : S_STAGED) : S_RUN;
            default:  nxt = S_RUN;
        endcase
    end

    // Output process
    always_comb begin
        late_clr = (state == S_LOAD);
    end

    // Staging word
    always_ff @(posedge clk) begin
        if (!rst_n)
            staged <= '0;
        else if (wr_en) begin
            for (int i = 0; i < BYTES; i++)
                if (addr == ADDR_W'(i))
                    staged[i*BYTE_W +: BYTE_W] <= wdata;
        end
    end

    // Live count: load beats tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (state == S_LOAD)
            count <= staged;
        else if (sec_tick)
            count <= count + 1'b1;
    end

    always_comb begin
        snap_byte = '0;
        for (int i = 1; i < BYTES; i++)
            if (addr == ADDR_W'(i))
                snap_byte = snap[i*BYTE_W +: BYTE_W];
    end

    // Read path with snapshot on byte 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap  <= '0;
            rdata <= '0;
        end else if (rd_en) begin
            if (addr == '0) begin
                snap  <= count;
                rdata <= count[BYTE_W-1:0];
            end else begin
                rdata <= snap_byte;
            end
        end
    end

    // R8: loaded value wins over any coincident tick
    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD) |=> (count == $past(staged)));

    // R1: count steps by one on a tick outside a load
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_LOAD && sec_tick) |=> (count == CNT_W'($past(count) + 1'b1)));

    // R3: no tick and no load leaves the count still
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_LOAD && !sec_tick) |=> $stable(count));

    // R2: snapshot moves only on a byte-0 read
    p_snap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == '0) |=> $stable(snap));
endmodule

// File: rtl/sc_sqw.sv
module sc_sqw (
    input  logic       sqw_en,
    input  logic [1:0] sqw_sel,
    input  logic       ref_en,
    input  logic [1:0] early_top,
    input  logic       late_msb,
    output logic       sqw
);
    logic pick;

    always_comb begin
        unique case (sqw_sel)
            2'd0:    pick = late_msb;
            2'd1:    pick = early_top[1];
            2'd2:    pick = early_top[0];
            default: pick = ref_en;
        endcase
        sqw = sqw_en & pick;
    end
endmodule

// File: rtl/secs_counter.sv
module secs_counter #(
    parameter int EARLY_W = 3,
    parameter int LATE_W  = 12,
    parameter int CNT_W   = 32,
    localparam int BYTES  = CNT_W / 8,
    localparam int ADDR_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              sqw_en,
    input  logic [1:0]        sqw_sel,
    output logic              sqw,
    output logic              wd_tick
);
    logic       late_clr, late_msb, sec_tick;
    logic [1:0] early_top;

    sc_divider #(.EARLY_W(EARLY_W), .LATE_W(LATE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .late_clr(late_clr),
        .early_top(early_top), .late_msb(late_msb),
        .wd_tick(wd_tick), .sec_tick(sec_tick)
    );

    sc_regs #(.CNT_W(CNT_W), .BYTES(BYTES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .late_clr(late_clr)
    );

    sc_sqw u_sqw (
        .sqw_en(sqw_en), .sqw_sel(sqw_sel), .ref_en(ref_en),
        .early_top(early_top), .late_msb(late_msb), .sqw(sqw)
    );

    // R5: after a load edge the 1 Hz source is low
    p_realign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        late_clr |=> !late_msb);
endmodule

// File: tb/secs_counter_bench.sv
module secs_counter_bench;
    localparam int EW  = 3;
    localparam int LW  = 3;
    localparam int SEC = 1 << (EW + LW);
    localparam int EP  = 1 << EW;

    logic clk = 0, rst_n = 0, ref_en = 0, rd_en = 0, wr_en = 0;
    logic [1:0] addr = '0, sqw_sel = '0;
    logic [7:0] wdata = '0;
    logic sqw_en = 0;
    logic [7:0] rdata;
    logic sqw, wd_tick;

    int n_chk = 0, n_fail = 0, ref_cnt = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    logic due = 0;
    bit done = 0;

    always #10 clk = ~clk;

    secs_counter #(.EARLY_W(EW), .LATE_W(LW)) u_secs_counter (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .rd_en(rd_en),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .sqw_en(sqw_en), .sqw_sel(sqw_sel), .sqw(sqw), .wd_tick(wd_tick)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: compare read bytes as they appear
    always @(posedge clk) due <= rd_en;
    always @(negedge clk) begin
        if (due && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rdata == e, t, rdata, e);
        end
    end

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ref_en = 1;
            @(negedge clk) ref_en = 0;
            ref_cnt++;
        end
    endtask

    task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk) begin wr_en = 1; addr = a; wdata = d; end
        @(negedge clk) wr_en = 0;
    endtask

    task automatic wr_word(input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr_byte(2'(i), v[i*8 +: 8]);
        @(negedge clk);
    endtask

    task automatic rd_byte(input logic [1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk) begin rd_en = 1; addr = a; end
        @(negedge clk) rd_en = 0;
    endtask

    task automatic rd_word(input logic [31:0] v, input string t);
        for (int i = 0; i < 4; i++) rd_byte(2'(i), v[i*8 +: 8], t);
    endtask

    function automatic int to_tick();
        return SEC - (ref_cnt % EP);
    endfunction

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        check(rdata == 0, "R9 rdata reset", rdata, 0);
        check(sqw == 0, "R9 sqw reset", sqw, 0);
        check(wd_tick == 0, "R9 wd_tick reset", wd_tick, 0);
        rd_word(32'h0, "R9 count reset");

        // R1/R3 byte order and load
        wr_word(32'h11223344);
        rd_word(32'h11223344, "R1 byte order");
        // R3 partial staging leaves count
        wr_byte(0, 8'hAA); wr_byte(1, 8'hBB); wr_byte(2, 8'hCC);
        @(negedge clk);
        rd_word(32'h11223344, "R3 partial write");

        // R4 full second after load, R1 carry
        pulse(3);
        n = to_tick();
        wr_word(32'h000000FF);
        pulse(n - 1);
        rd_word(32'h000000FF, "R4 before tick");
        pulse(1);
        rd_word(32'h00000100, "R4 R1 tick carry");

        // R2 snapshot
        n = to_tick();
        wr_word(32'h000012FF);
        rd_byte(0, 8'hFF, "R2 snap low");
        pulse(n);
        rd_byte(1, 8'h12, "R2 snap b1");
        rd_byte(2, 8'h00, "R2 snap b2");
        rd_byte(3, 8'h00, "R2 snap b3");
        rd_byte(0, 8'h00, "R2 live low");
        rd_byte(1, 8'h13, "R2 live b1");

        // R6/R7 early stage and fast waves
        sqw_en = 1;
        pulse((5 - (ref_cnt % EP) + EP) % EP);
        sqw_sel = 1; #1;
        check(sqw == 1, "R7 sel1 before load", sqw, 1);
        sqw_sel = 2; #1;
        check(sqw == 0, "R7 sel2 before load", sqw, 0);
        wr_word(32'hCAFE0000);
        #1;
        check(sqw == 0, "R6 sel2 after load", sqw, 0);
        sqw_sel = 1; #1;
        check(sqw == 1, "R6 sel1 after load", sqw, 1);
        pulse(2);
        @(negedge clk) ref_en = 1;
        #1 check(wd_tick == 1, "R6 wd_tick", wd_tick, 1);
        @(negedge clk) ref_en = 0;
        ref_cnt++;
        #1 check(wd_tick == 0, "R6 wd_tick idle", wd_tick, 0);

        // R5 1 Hz realign
        sqw_sel = 0;
        wr_word(32'h00000001);
        #1 check(sqw == 0, "R5 1Hz after load", sqw, 0);
        pulse((SEC / 2) - (ref_cnt % EP));
        #1 check(sqw == 1, "R5 1Hz half second", sqw, 1);
        wr_word(32'h00000005);
        #1 check(sqw == 0, "R5 1Hz realigned", sqw, 0);
        rd_word(32'h00000005, "R5 count loaded");

        // R7 select 3 and enable
        sqw_sel = 3;
        @(negedge clk) ref_en = 1;
        #1 check(sqw == 1, "R7 sel3 follows ref", sqw, 1);
        sqw_en = 0;
        #1 check(sqw == 0, "R7 disabled", sqw, 0);
        @(negedge clk) ref_en = 0;
        ref_cnt++;

        // R8 collision of tick and load
        n = to_tick();
        wr_word(32'h0);
        pulse(n - 1);
        wr_byte(0, 8'h77); wr_byte(1, 8'h66); wr_byte(2, 8'h55);
        wr_byte(3, 8'h44);
        ref_en = 1;
        @(negedge clk) ref_en = 0;
        ref_cnt++;
        rd_word(32'h44556677, "R8 load wins");
        pulse(SEC - 1);
        rd_word(32'h44556677, "R4 after collision");
        pulse(1);
        rd_word(32'h44556678, "R4 tick after collision");

        // R1 wrap
        n = to_tick();
        wr_word(32'hFFFFFFFF);
        pulse(n);
        rd_word(32'h0, "R1 wrap");

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule